// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block collects seven interrupt requests for an 8051-class processor core. It applies a per-source enable mask and a master enable, and gives each source one of two priority levels. It then offers one winning request to the core as a registered valid flag together with a 16-bit service address. Two of the sources come from external active-low pins. Each pin passes through a synchronizer and can be set to level or edge sensitivity. The second pin, in edge mode, reacts to both transitions, so that software can time the width of a pulse. The remaining five sources are level requests from on-chip peripherals.

The core takes an offer by pulsing `ack`, and it pulses `reti` when a service routine ends. The block keeps one in-service bit for each priority level. These bits apply the nesting rule: a high-level request may interrupt a low-level routine, nothing interrupts a high-level routine, and a low-level request waits until no routine is running. Once an offer is raised, it stays unchanged until the core takes it. A new offer is formed only when no offer is pending.

Top module: `irq_arbiter7`

## Requirements
- R1: After a synchronous reset, `irq_valid` is low and both in-service levels are idle, even if requests are present.
- R2: Slot numbers run 0 to 6 in the order ext0, periph_req[0], ext1, periph_req[1], periph_req[2], periph_req[3], periph_req[4]. Among eligible requests of one level, the lowest slot number wins.
- R3: The offered address is 0x0003 + 8 × slot, giving 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, 0x002B and 0x0033 for slots 0 to 6.
- R4: `ie_mask[i]` enables slot i. `ie_mask[7]` is a master enable, and while it is 0 no request is offered.
- R5: `prio_mask[i]=1` places slot i at the high level. When eligible requests of both levels are present, a high-level request wins over any low-level one, whatever its slot number.
- R6: While `irq_valid` is high and `ack` is low, `irq_valid` stays high and `irq_vector` does not change, even if the requests change.
- R7: While a low-level routine is in service, low-level requests are not offered and high-level requests are.
- R8: While a high-level routine is in service, no request is offered.
- R9: `ack` while `irq_valid` is high drops `irq_valid` on the next cycle and marks the offered level as in service. `reti` clears the high in-service bit if it is set, and otherwise clears the low one.
- R10: When `edge_mode[k]=0`, external pin k requests while its synchronized value is low. A low level that ends before it is enabled leaves no request behind.
- R11: When `edge_mode[0]=1`, a falling edge on ext_n[0] latches a request that stays set until that slot is acknowledged. A rising edge latches nothing.
- R12: When `edge_mode[1]=1`, both falling and rising edges on ext_n[1] latch a request, which is cleared when that slot is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_mask | input | 8 | Per-slot enables in bits 6:0; bit 7 is the master enable |
| prio_mask | input | 7 | Per-slot level, 1 = high |
| edge_mode | input | 2 | Per-pin sensitivity, 1 = edge, 0 = level |
| ext_n | input | 2 | Asynchronous active-low external request pins |
| periph_req | input | 5 | Active-high level requests from on-chip peripherals |
| ack | input | 1 | Core takes the current offer (one-cycle pulse) |
| reti | input | 1 | Core ends a service routine (one-cycle pulse) |
| irq_valid | output | 1 | An offer is pending |
| irq_vector | output | 16 | Service address of the pending offer |

## Verification
A wrong in-service bit can only be seen in later offers. A stuck low bit hides every low-level request. A stuck high bit hides everything. A bit that is cleared too early lets a request preempt a routine it should not, and this shows as a raised `irq_valid` a few cycles after the request appears. A lost or never-cleared edge flag shows as a missing offer, or as a repeated offer, after the source is enabled or acknowledged. The bench therefore builds nested ack/reti sequences and reads `irq_valid` and `irq_vector` three to five cycles after each change. That is the full latency of the synchronizer, the flag and the offer register.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NUM_SRC    = 7;
  localparam int unsigned NUM_EXT    = 2;
  localparam int unsigned NUM_PERIPH = NUM_SRC - NUM_EXT;
  localparam int unsigned IDX_W      = $clog2(NUM_SRC);

  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} lvl_e;

  // external pin k sits at slot 2k (slots 0 and 2)
  function automatic int unsigned ext_slot(input int unsigned k);
    return 2 * k;
  endfunction

  // peripheral line p fills the remaining slots 1, 3, 4, 5, 6
  function automatic int unsigned periph_slot(input int unsigned p);
    return (p < 2) ? (2 * p + 1) : (p + 2);
  endfunction
endpackage

// File: rtl/irq_ext_sync.sv
module irq_ext_sync #(
  parameter int unsigned STAGES     = 2,
  parameter bit          BOTH_EDGES = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [STAGES-1:0] chain;
  logic prev;
  logic flag;
  logic synced;
  logic fall, rise, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign synced = chain[STAGES-1];
  assign fall   = prev & ~synced;
  assign rise   = ~prev & synced;
  assign hit    = fall | (BOTH_EDGES & rise);

  always_ff @(posedge clk) begin
    if (rst || !edge_mode) flag <= 1'b0;
    else if (hit)          flag <= 1'b1;
    else if (clr)          flag <= 1'b0;
  end

  assign req = edge_mode ? flag : ~synced;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     hi,
  input  logic             allow_hi,
  input  logic             allow_lo,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             lvl
);
  logic             hi_f, lo_f;
  logic [IDX_W-1:0] hi_i, lo_i;

  // scan from the top down so the lowest slot is written last
  always_comb begin
    hi_f = 1'b0; lo_f = 1'b0;
    hi_i = '0;   lo_i = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && hi[i]) begin
        hi_f = 1'b1;
        hi_i = IDX_W'(i);
      end
      if (pend[i] && !hi[i]) begin
        lo_f = 1'b1;
        lo_i = IDX_W'(i);
      end
    end
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = 1'b0;
    if (hi_f && allow_hi) begin
      found = 1'b1;
      idx   = hi_i;
      lvl   = 1'b1;
    end else if (lo_f && allow_lo) begin
      found = 1'b1;
      idx   = lo_i;
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
  input  logic       clk,
  input  logic       rst,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       ret,
  output logic [1:0] ins,
  output logic       allow_hi,
  output logic       allow_lo
);
  logic [1:0] nxt;

  always_comb begin
    nxt = ins;
    if (ret) begin
      if (ins[1]) nxt[1] = 1'b0;
      else        nxt[0] = 1'b0;
    end
    if (take) nxt[take_lvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ins <= 2'b00;
    else     ins <= nxt;
  end

  assign allow_hi = ~ins[1];
  assign allow_lo = (ins == 2'b00);
endmodule

// File: rtl/irq_arbiter7.sv
module irq_arbiter7
  import irq_arb_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned VEC_BASE    = 3,
  parameter int unsigned VEC_STRIDE  = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC:0]      ie_mask,
  input  logic [NUM_SRC-1:0]    prio_mask,
  input  logic [NUM_EXT-1:0]    edge_mode,
  input  logic [NUM_EXT-1:0]    ext_n,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic                  ack,
  input  logic                  reti,
  output logic                  irq_valid,
  output logic [ADDR_W-1:0]     irq_vector
);
  logic [NUM_SRC-1:0] pend, gated;
  logic [NUM_EXT-1:0] ext_req, ext_clr;
  logic               ack_ok;
  logic [IDX_W-1:0]   cur_idx, pick_idx;
  logic               cur_lvl, pick_lvl, pick_found;
  logic [1:0]         in_svc;
  logic               allow_hi, allow_lo;
  logic [ADDR_W-1:0]  vec_nxt;

  assign ack_ok = ack & irq_valid;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    irq_ext_sync #(
      .STAGES    (SYNC_STAGES),
      .BOTH_EDGES(k == 1)
    ) u_sync (
      .clk      (clk),
      .rst      (rst),
      .pin_n    (ext_n[k]),
      .edge_mode(edge_mode[k]),
      .clr      (ext_clr[k]),
      .req      (ext_req[k])
    );
    assign ext_clr[k] = ack_ok & (cur_idx == IDX_W'(ext_slot(k)));
    assign pend[ext_slot(k)] = ext_req[k];
  end

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
    assign pend[periph_slot(p)] = periph_req[p];
  end

  assign gated = pend & ie_mask[NUM_SRC-1:0] & {NUM_SRC{ie_mask[NUM_SRC]}};

  irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend    (gated),
    .hi      (prio_mask),
    .allow_hi(allow_hi),
    .allow_lo(allow_lo),
    .found   (pick_found),
    .idx     (pick_idx),
    .lvl     (pick_lvl)
  );

  irq_nest u_nest (
    .clk     (clk),
    .rst     (rst),
    .take    (ack_ok),
    .take_lvl(cur_lvl),
    .ret     (reti),
    .ins     (in_svc),
    .allow_hi(allow_hi),
    .allow_lo(allow_lo)
  );

  assign vec_nxt = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(pick_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
      cur_idx    <= '0;
      cur_lvl    <= LVL_LOW;
    end else if (ack_ok) begin
      irq_valid <= 1'b0;
    end else if (!irq_valid && pick_found) begin
      irq_valid  <= 1'b1;
      irq_vector <= vec_nxt;
      cur_idx    <= pick_idx;
      cur_lvl    <= pick_lvl;
    end
  end
endmodule

// File: rtl/irq_arbiter7_chk.sv
module irq_arbiter7_chk #(
  parameter int unsigned NUM_SRC    = 7,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_SRC:0]  ie_mask,
  input logic              ack,
  input logic              irq_valid,
  input logic [ADDR_W-1:0] irq_vector,
  input logic [1:0]        ins,
  input logic              cur_lvl
);
  localparam int unsigned TOP_VEC = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_valid && ins == 2'b00));

  a_r6_offer_held: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !ack) |=> (irq_valid && $stable(irq_vector)));

  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && ack) |=> !irq_valid);

  a_r8_high_blocks_all: assert property (@(posedge clk) disable iff (rst)
    ins[1] |-> !irq_valid);

  a_r7_low_blocks_low: assert property (@(posedge clk) disable iff (rst)
    (ins[0] && irq_valid) |-> cur_lvl);

  a_r4_master_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid) |-> $past(ie_mask[NUM_SRC]));

  a_r3_vector_grid: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (int'(irq_vector) >= int'(VEC_BASE) && int'(irq_vector) <= int'(TOP_VEC)
                   && ((int'(irq_vector) - int'(VEC_BASE)) % int'(VEC_STRIDE)) == 0));
endmodule

bind irq_arbiter7 irq_arbiter7_chk #(
  .NUM_SRC   (irq_arb_pkg::NUM_SRC),
  .ADDR_W    (ADDR_W),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ie_mask   (ie_mask),
  .ack       (ack),
  .irq_valid (irq_valid),
  .irq_vector(irq_vector),
  .ins       (in_svc),
  .cur_lvl   (cur_lvl)
);

// File: tb/irq_arbiter7_test.sv
module irq_arbiter7_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  ie_mask;
  logic [6:0]  prio_mask;
  logic [1:0]  edge_mode;
  logic [1:0]  ext_n;
  logic [4:0]  periph_req;
  logic        ack, reti;
  logic        irq_valid;
  logic [15:0] irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_arbiter7 uut (
    .clk(clk), .rst(rst), .ie_mask(ie_mask), .prio_mask(prio_mask),
    .edge_mode(edge_mode), .ext_n(ext_n), .periph_req(periph_req),
    .ack(ack), .reti(reti), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_offer(input string tag, input int vec);
    check_eq({tag, " valid"}, int'(irq_valid), 1);
    check_eq({tag, " vector"}, int'(irq_vector), vec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ie_mask = '0; prio_mask = '0; edge_mode = '0;
    ext_n = 2'b11; periph_req = '0; ack = 1'b0; reti = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(1); reti = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; periph_req = 5'b11111; ie_mask = 8'hFF; ack = 1'b0; reti = 1'b0;
    tick(3);
    check_eq("R1 valid during reset", int'(irq_valid), 0);
    do_reset();
    check_eq("R1 valid after reset", int'(irq_valid), 0);
  endtask

  task automatic t_order();
    do_reset();
    ie_mask = 8'hFF;
    periph_req = 5'b11111;
    tick(3);
    check_offer("R2 R3 slot1 first", 16'h000B);
    for (int p = 0; p < 4; p++) begin
      pulse_ack();
      periph_req[p] = 1'b0;
      pulse_reti();
      tick(3);
      case (p)
        0: check_offer("R2 R3 slot3 next", 16'h001B);
        1: check_offer("R2 R3 slot4 next", 16'h0023);
        2: check_offer("R2 R3 slot5 next", 16'h002B);
        default: check_offer("R2 R3 slot6 last", 16'h0033);
      endcase
    end
  endtask

  task automatic t_enable();
    do_reset();
    periph_req = 5'b00100;
    ie_mask = 8'h10;
    tick(4);
    check_eq("R4 master enable off", int'(irq_valid), 0);
    ie_mask = 8'h90;
    tick(3);
    check_offer("R4 master enable on", 16'h0023);
    do_reset();
    periph_req = 5'b10100;
    ie_mask = 8'hC0;
    tick(4);
    check_offer("R4 slot4 masked", 16'h0033);
  endtask

  task automatic t_prio();
    do_reset();
    ie_mask = 8'hFF;
    prio_mask = 7'h40;
    periph_req = 5'b10001;
    tick(4);
    check_offer("R5 high beats order", 16'h0033);
  endtask

  task automatic t_hold();
    do_reset();
    ie_mask = 8'hFF;
    periph_req = 5'b00010;
    tick(3);
    check_offer("R6 first offer", 16'h001B);
    periph_req = 5'b00001;
    tick(4);
    check_offer("R6 held after change", 16'h001B);
  endtask

  task automatic t_nest();
    do_reset();
    ie_mask = 8'hFF;
    prio_mask = 7'h40;
    periph_req = 5'b00010;
    tick(3);
    check_offer("R7 low offer", 16'h001B);
    pulse_ack();
    check_eq("R9 valid drops after ack", int'(irq_valid), 0);
    periph_req = 5'b00011;
    tick(4);
    check_eq("R7 low blocked by low", int'(irq_valid), 0);
    periph_req = 5'b10011;
    tick(3);
    check_offer("R7 high preempts low", 16'h0033);
    pulse_ack();
    periph_req = 5'b00011;
    prio_mask = 7'h50;
    periph_req = 5'b00111;
    tick(4);
    check_eq("R8 high blocked by high", int'(irq_valid), 0);
    pulse_reti();
    tick(3);
    check_offer("R9 reti clears high first", 16'h0023);
    pulse_ack();
    periph_req = 5'b00011;
    pulse_reti();
    tick(4);
    check_eq("R9 low still in service", int'(irq_valid), 0);
    pulse_reti();
    tick(3);
    check_offer("R9 second reti frees low", 16'h000B);
  endtask

  task automatic t_ext_level();
    do_reset();
    ie_mask = 8'h80;
    ext_n[0] = 1'b0;
    tick(5);
    ext_n[0] = 1'b1;
    tick(5);
    ie_mask = 8'h81;
    tick(4);
    check_eq("R10 level not latched", int'(irq_valid), 0);
    ext_n[0] = 1'b0;
    tick(5);
    check_offer("R10 ext0 level low", 16'h0003);
    do_reset();
    ie_mask = 8'h84;
    ext_n[1] = 1'b0;
    tick(5);
    check_offer("R10 ext1 level low", 16'h0013);
  endtask

  task automatic t_ext0_edge();
    do_reset();
    ie_mask = 8'h80;
    edge_mode = 2'b01;
    ext_n[0] = 1'b0;
    tick(5);
    ext_n[0] = 1'b1;
    tick(5);
    ie_mask = 8'h81;
    tick(3);
    check_offer("R11 falling edge latched", 16'h0003);
    pulse_ack();
    pulse_reti();
    tick(4);
    check_eq("R11 flag cleared by ack", int'(irq_valid), 0);
    do_reset();
    ie_mask = 8'h80;
    ext_n[0] = 1'b0;
    tick(5);
    edge_mode = 2'b01;
    tick(2);
    ext_n[0] = 1'b1;
    tick(5);
    ie_mask = 8'h81;
    tick(4);
    check_eq("R11 rising edge ignored", int'(irq_valid), 0);
  endtask

  task automatic t_ext1_both();
    do_reset();
    ie_mask = 8'h80;
    edge_mode = 2'b10;
    ext_n[1] = 1'b0;
    tick(5);
    ie_mask = 8'h84;
    tick(3);
    check_offer("R12 falling edge latched", 16'h0013);
    pulse_ack();
    pulse_reti();
    tick(4);
    check_eq("R12 flag cleared by ack", int'(irq_valid), 0);
    ie_mask = 8'h80;
    ext_n[1] = 1'b1;
    tick(5);
    ie_mask = 8'h84;
    tick(3);
    check_offer("R12 rising edge latched", 16'h0013);
  endtask

  initial begin
    t_reset();
    t_order();
    t_enable();
    t_prio();
    t_hold();
    t_nest();
    t_ext_level();
    t_ext0_edge();
    t_ext1_both();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule